// File: doc/BRIEF.md
# Host I/O Space Decoder

This block sits on the host side of a bridge and sorts processor I/O cycles. Each cycle brings an I/O address, an access size of one, two or four bytes, and a read/write flag. The decoder decides whether the bridge itself answers the cycle or whether the cycle goes on to the downstream bridge. The bridge answers only for its two configuration-access ports: an address port that holds a 32-bit configuration pointer, and a data port. Every other cycle is forwarded with its address untouched.

Multi-byte accesses near the top of the 64 KB I/O space can run past 0xFFFF. For these the decoder raises a seventeenth address bit, the wrap bit, next to the forwarded address. With this bit the space holds 64K+3 byte locations. The three locations above 0xFFFF can only be reached this way.

All results are registered. They come out together, one clock after the cycle is presented, and `out_valid` marks them. The pointer register has a most-significant enable bit. When that bit is clear, data-port accesses are forwarded instead of claimed. Producing the configuration cycles themselves is left to the logic that consumes the claim.

Top module: `host_io_decoder`

## Requirements
- R1: When `in_valid` is high, `out_valid` is high on the next cycle. After a cycle with `in_valid` low, `out_valid`, `out_claim` and `out_fwd` are all low. All three are low after reset.
- R2: Whenever `out_valid` is high, exactly one of `out_claim` and `out_fwd` is high.
- R3: The pointer port at 0x0CF8 is claimed only for a 4-byte access (size code 2). A 1-byte access (code 0) or a 2-byte access (code 1) at 0x0CF8 is forwarded and leaves the pointer register unchanged.
- R4: A claimed write to the pointer port stores `in_wdata` with bits 1:0 forced to zero. A later claimed read of the port returns the stored value on `out_rdata`. The register is zero after reset.
- R5: When pointer bit 31 is set, an access is claimed if it starts at 0x0CFC or above and its last byte is at or below 0x0CFF. An access to the data port that runs past 0x0CFF is forwarded.
- R6: When pointer bit 31 is clear, accesses to the data port are forwarded. A pointer write takes effect for the very next cycle.
- R7: `out_addr` equals the `in_addr` of the cycle being reported, with no translation.
- R8: `out_wrap` is high for a 4-byte access starting at 0xFFFD, 0xFFFE or 0xFFFF, and for a 2-byte access starting at 0xFFFF.
- R9: `out_wrap` is low for every 1-byte access and for every access whose last byte is at or below 0xFFFF.
- R10: `out_rdata` is zero for every result other than a claimed read of the pointer port.
- R11: Size code 3 is reserved. Such a cycle is forwarded, is never claimed and never raises `out_wrap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An I/O cycle is presented this clock |
| in_addr | input | 16 | I/O start address |
| in_size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved |
| in_write | input | 1 | 1 = write, 0 = read |
| in_wdata | input | 32 | Write data |
| out_valid | output | 1 | Result of the previous clock's cycle |
| out_claim | output | 1 | The bridge answers the cycle itself |
| out_fwd | output | 1 | The cycle goes to the downstream bridge |
| out_addr | output | 16 | Address passed downstream |
| out_wrap | output | 1 | Address bit 16 for accesses that wrap |
| out_rdata | output | 32 | Read data for a claimed pointer read |

## Verification
Every result appears exactly one clock after its cycle is presented. Pointer writes land on that same edge, so a data-port access in the following cycle already sees the new enable. The bench drives a cycle at a falling edge and checks its result at the next falling edge, one rising edge later. It drives the next cycle at that same falling edge, so cycles run back to back and the one-cycle ordering of enable changes is exercised. Idle and reset results are sampled one falling edge after the condition is set up.

// File: rtl/hiod_pkg.sv
package hiod_pkg;

  typedef enum logic [1:0] {
    SZ_B1  = 2'd0,
    SZ_B2  = 2'd1,
    SZ_B4  = 2'd2,
    SZ_RSV = 2'd3
  } io_size_e;

  // offset of the last byte of an access from its first byte
  function automatic logic [1:0] last_byte_off(io_size_e sz);
    case (sz)
      SZ_B2:   last_byte_off = 2'd1;
      SZ_B4:   last_byte_off = 2'd3;
      default: last_byte_off = 2'd0;
    endcase
  endfunction

  function automatic logic size_legal(io_size_e sz);
    size_legal = (sz != SZ_RSV);
  endfunction

endpackage

// File: rtl/hiod_span.sv
module hiod_span
  import hiod_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  io_size_e          size,
  output logic [ADDR_W:0]   last_addr,
  output logic              wrap
);

  localparam int EXT_W = ADDR_W + 1;

  logic [1:0] off;
  logic       legal;

  always_comb begin
    off       = last_byte_off(size);
    legal     = size_legal(size);
    last_addr = {1'b0, addr} + {{(EXT_W-2){1'b0}}, off};
    // carry out of the top address bit means the access crosses the top
    wrap      = legal & last_addr[ADDR_W];
  end

endmodule

// File: rtl/hiod_match.sv
module hiod_match
  import hiod_pkg::*;
#(
  parameter int                ADDR_W        = 16,
  parameter logic [ADDR_W-1:0] CFG_ADDR_PORT = 16'h0CF8,
  parameter logic [ADDR_W-1:0] CFG_DATA_PORT = 16'h0CFC,
  parameter int                DATA_SPAN     = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  io_size_e          size,
  input  logic [ADDR_W:0]   last_addr,
  input  logic              cfg_enable,
  output logic              hit_ptr,
  output logic              hit_data
);

  localparam int            EXT_W     = ADDR_W + 1;
  localparam logic [ADDR_W:0] DATA_LO = {1'b0, CFG_DATA_PORT};
  localparam logic [ADDR_W:0] DATA_HI = DATA_LO + EXT_W'(DATA_SPAN - 1);

  logic in_window;

  always_comb begin
    hit_ptr   = (size == SZ_B4) && (addr == CFG_ADDR_PORT);
    in_window = size_legal(size)
             && ({1'b0, addr} >= DATA_LO)
             && (last_addr <= DATA_HI);
    hit_data  = cfg_enable && in_window;
  end

endmodule

// File: rtl/hiod_cfgptr.sv
module hiod_cfgptr #(
  parameter int DATA_W    = 32,
  parameter int RSVD_LSBS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ptr_q
);

  localparam logic [DATA_W-1:0] KEEP_MASK =
    {{(DATA_W-RSVD_LSBS){1'b1}}, {RSVD_LSBS{1'b0}}};

  logic [DATA_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (wr_en) ptr_d = wdata & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (wr_en) ptr_q <= ptr_d;
  end

  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ptr_q))
    else $error("pointer changed without a claimed write");

  assert_ptr_lsbs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr_q[RSVD_LSBS-1:0] == '0)
    else $error("pointer reserved bits not zero");

endmodule

// File: rtl/host_io_decoder.sv
module host_io_decoder
  import hiod_pkg::*;
#(
  parameter int                ADDR_W        = 16,
  parameter int                DATA_W        = 32,
  parameter logic [ADDR_W-1:0] CFG_ADDR_PORT = 16'h0CF8,
  parameter logic [ADDR_W-1:0] CFG_DATA_PORT = 16'h0CFC,
  parameter int                EN_BIT        = 31,
  parameter int                RSVD_LSBS     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [1:0]        in_size,
  input  logic              in_write,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              out_valid,
  output logic              out_claim,
  output logic              out_fwd,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_wrap,
  output logic [DATA_W-1:0] out_rdata
);

  localparam int DATA_SPAN = 1 << RSVD_LSBS;

  io_size_e          size_e;
  logic [ADDR_W:0]   last_addr;
  logic              span_wrap;
  logic              hit_ptr;
  logic              hit_data;
  logic [DATA_W-1:0] ptr_q;
  logic              ptr_wr;

  logic              valid_d, claim_d, fwd_d, wrap_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] rdata_d;

  assign size_e = io_size_e'(in_size);

  hiod_span #(.ADDR_W(ADDR_W)) u_span (
    .addr      (in_addr),
    .size      (size_e),
    .last_addr (last_addr),
    .wrap      (span_wrap)
  );

  hiod_match #(
    .ADDR_W        (ADDR_W),
    .CFG_ADDR_PORT (CFG_ADDR_PORT),
    .CFG_DATA_PORT (CFG_DATA_PORT),
    .DATA_SPAN     (DATA_SPAN)
  ) u_match (
    .addr       (in_addr),
    .size       (size_e),
    .last_addr  (last_addr),
    .cfg_enable (ptr_q[EN_BIT]),
    .hit_ptr    (hit_ptr),
    .hit_data   (hit_data)
  );

  hiod_cfgptr #(.DATA_W(DATA_W), .RSVD_LSBS(RSVD_LSBS)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (ptr_wr),
    .wdata (in_wdata),
    .ptr_q (ptr_q)
  );

  // next-state for the result stage
  always_comb begin
    ptr_wr  = in_valid && in_write && hit_ptr;
    valid_d = in_valid;
    claim_d = in_valid && (hit_ptr || hit_data);
    fwd_d   = in_valid && !(hit_ptr || hit_data);
    addr_d  = in_valid ? in_addr : '0;
    wrap_d  = in_valid && span_wrap;
    rdata_d = (in_valid && !in_write && hit_ptr) ? ptr_q : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_claim <= 1'b0;
      out_fwd   <= 1'b0;
      out_addr  <= '0;
      out_wrap  <= 1'b0;
      out_rdata <= '0;
    end else begin
      out_valid <= valid_d;
      out_claim <= claim_d;
      out_fwd   <= fwd_d;
      out_addr  <= addr_d;
      out_wrap  <= wrap_d;
      out_rdata <= rdata_d;
    end
  end

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_claim && !out_fwd))
    else $error("result raised after an idle cycle");

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid)
    else $error("result missing one cycle after a request");

  assert_one_route_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones({out_claim, out_fwd}) == 1))
    else $error("claim and forward not exclusive");

  assert_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_addr == $past(in_addr)))
    else $error("forwarded address altered");

  assert_no_wrap_1b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_size == 2'd0) |=> !out_wrap)
    else $error("wrap raised on a single-byte access");

  assert_rsv_size_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_size == 2'd3) |=> (out_fwd && !out_wrap))
    else $error("reserved size not forwarded plainly");

  assert_write_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_write) |=> (out_rdata == '0))
    else $error("read data on a write result");

endmodule

// File: tb/host_io_decoder_tb_top.sv
module host_io_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_addr;
  logic [1:0]  in_size;
  logic        in_write;
  logic [31:0] in_wdata;
  logic        out_valid, out_claim, out_fwd, out_wrap;
  logic [15:0] out_addr;
  logic [31:0] out_rdata;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  host_io_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .in_size(in_size), .in_write(in_write), .in_wdata(in_wdata),
    .out_valid(out_valid), .out_claim(out_claim), .out_fwd(out_fwd),
    .out_addr(out_addr), .out_wrap(out_wrap), .out_rdata(out_rdata)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [15:0] addr;
    logic [1:0]  size;
    logic        wr;
    logic [31:0] wdata;
    logic        claim;
    logic        wrap;
    logic [31:0] rdata;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{4'd4,  16'h0CF8, 2'd2, 1'b0, 32'h0,         1'b1, 1'b0, 32'h0},
    '{4'd10, 16'h0CF8, 2'd2, 1'b1, 32'h8000_1237, 1'b1, 1'b0, 32'h0},
    '{4'd4,  16'h0CF8, 2'd2, 1'b0, 32'h0,         1'b1, 1'b0, 32'h8000_1234},
    '{4'd3,  16'h0CF8, 2'd0, 1'b0, 32'h0,         1'b0, 1'b0, 32'h0},
    '{4'd3,  16'h0CF8, 2'd1, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0},
    '{4'd3,  16'h0CF8, 2'd2, 1'b0, 32'h0,         1'b1, 1'b0, 32'h8000_1234},
    '{4'd5,  16'h0CFC, 2'd2, 1'b0, 32'h0,         1'b1, 1'b0, 32'h0},
    '{4'd5,  16'h0CFE, 2'd1, 1'b1, 32'h1234_5678, 1'b1, 1'b0, 32'h0},
    '{4'd5,  16'h0CFF, 2'd0, 1'b0, 32'h0,         1'b1, 1'b0, 32'h0},
    '{4'd5,  16'h0CFF, 2'd1, 1'b0, 32'h0,         1'b0, 1'b0, 32'h0},
    '{4'd5,  16'h0CFD, 2'd2, 1'b0, 32'h0,         1'b0, 1'b0, 32'h0},
    '{4'd8,  16'hFFFD, 2'd2, 1'b0, 32'h0,         1'b0, 1'b1, 32'h0},
    '{4'd8,  16'hFFFE, 2'd2, 1'b1, 32'h0,         1'b0, 1'b1, 32'h0},
    '{4'd8,  16'hFFFF, 2'd2, 1'b0, 32'h0,         1'b0, 1'b1, 32'h0},
    '{4'd8,  16'hFFFF, 2'd1, 1'b0, 32'h0,         1'b0, 1'b1, 32'h0},
    '{4'd9,  16'hFFFF, 2'd0, 1'b0, 32'h0,         1'b0, 1'b0, 32'h0},
    '{4'd9,  16'hFFFC, 2'd2, 1'b0, 32'h0,         1'b0, 1'b0, 32'h0},
    '{4'd9,  16'hFFFE, 2'd1, 1'b0, 32'h0,         1'b0, 1'b0, 32'h0},
    '{4'd11, 16'h0CF8, 2'd3, 1'b0, 32'h0,         1'b0, 1'b0, 32'h0},
    '{4'd11, 16'hFFFF, 2'd3, 1'b0, 32'h0,         1'b0, 1'b0, 32'h0},
    '{4'd6,  16'h0CF8, 2'd2, 1'b1, 32'h0000_0802, 1'b1, 1'b0, 32'h0},
    '{4'd6,  16'h0CFC, 2'd2, 1'b0, 32'h0,         1'b0, 1'b0, 32'h0},
    '{4'd6,  16'h0CFD, 2'd0, 1'b1, 32'h0,         1'b0, 1'b0, 32'h0},
    '{4'd4,  16'h0CF8, 2'd2, 1'b0, 32'h0,         1'b1, 1'b0, 32'h0000_0800},
    '{4'd7,  16'h0080, 2'd0, 1'b1, 32'h0,         1'b0, 1'b0, 32'h0},
    '{4'd7,  16'h1234, 2'd1, 1'b0, 32'h0,         1'b0, 1'b0, 32'h0}
  };

  function automatic string rtag(logic [3:0] i);
    case (i)
      4'd1:  rtag = "R1";
      4'd2:  rtag = "R2";
      4'd3:  rtag = "R3";
      4'd4:  rtag = "R4";
      4'd5:  rtag = "R5";
      4'd6:  rtag = "R6";
      4'd7:  rtag = "R7";
      4'd8:  rtag = "R8";
      4'd9:  rtag = "R9";
      4'd10: rtag = "R10";
      default: rtag = "R11";
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [15:0] a, logic [1:0] s, logic w, logic [31:0] d);
    in_valid = v; in_addr = a; in_size = s; in_write = w; in_wdata = d;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    drive(1'b0, '0, '0, 1'b0, '0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // reset state, R1 and R10
    check("R1", "valid after reset", 32'(out_valid), 32'd0);
    check("R1", "claim after reset", 32'(out_claim), 32'd0);
    check("R1", "fwd after reset", 32'(out_fwd), 32'd0);
    check("R10", "rdata after reset", out_rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // vector table, cycles back to back, result due one rising edge later
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VECS[i].addr, VECS[i].size, VECS[i].wr, VECS[i].wdata);
      @(negedge clk);
      check(rtag(VECS[i].req), "valid", 32'(out_valid), 32'd1);
      check(rtag(VECS[i].req), "claim", 32'(out_claim), 32'(VECS[i].claim));
      check("R2", "fwd", 32'(out_fwd), 32'(!VECS[i].claim));
      check(rtag(VECS[i].req), "wrap", 32'(out_wrap), 32'(VECS[i].wrap));
      check("R7", "addr", 32'(out_addr), 32'(VECS[i].addr));
      check(rtag(VECS[i].req), "rdata", out_rdata, VECS[i].rdata);
    end

    // idle cycle: R1
    drive(1'b0, 16'h0CF8, 2'd2, 1'b0, '0);
    @(negedge clk);
    check("R1", "valid idle", 32'(out_valid), 32'd0);
    check("R1", "claim idle", 32'(out_claim), 32'd0);
    check("R1", "fwd idle", 32'(out_fwd), 32'd0);

    // set enable, then reset mid-run clears the pointer: R4
    drive(1'b1, 16'h0CF8, 2'd2, 1'b1, 32'h8000_00F0);
    @(negedge clk);
    drive(1'b0, '0, '0, 1'b0, '0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    drive(1'b1, 16'h0CF8, 2'd2, 1'b0, '0);
    @(negedge clk);
    check("R4", "pointer after mid-run reset", out_rdata, 32'd0);
    // enable cleared by reset, so the data port goes downstream: R6
    drive(1'b1, 16'h0CFC, 2'd2, 1'b0, '0);
    @(negedge clk);
    check("R6", "data port after reset", 32'(out_fwd), 32'd1);
    drive(1'b0, '0, '0, 1'b0, '0);
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule